// File: doc/BRIEF.md
# Conversion Group Status Tracker

This block keeps the status of one group of analog conversions and presents it as a 32-bit status word on a small register bus. It follows the control events of the conversion sequencer: group start, completion of each channel, freeze, resume and the continuous-mode setting. From these it derives a busy flag, a stopped flag and an end-of-group flag. It also counts the results written into the results buffer and not yet read in FIFO mode, and shows a results-empty flag from that count.

The end flag has four ways to be cleared: a FIFO-mode buffer read, a rewrite of the channel selection, a write of one to bit 0 on the bus, and dropping the module enable. Busy stays high while the group is frozen so that another group can be serviced, and stays high for as long as continuous mode is selected. Channel conversion, arbitration between groups and the result storage array itself lie outside the block. Only their control strobes enter it.

Status bit layout: bit 0 is the end flag, bit 1 is stopped, bit 2 is busy, bit 3 is results-empty, and bits 31:4 are zero. Every flag is registered. A strobe shows on `status` after the clock edge that samples it.

Top module: `grp_stat_tracker`

## Requirements
- R1: After reset, `status` reads 32'h0000_0008: results-empty is 1, busy, stopped and end are 0. `unread_cnt` is 0.
- R2: Bits 31:4 of `status` and of the read data are always zero. Bus writes with any value in bits 31:1 change no status bit.
- R3: `unread_cnt` rises by one on each `buf_wr` and falls by one on each `buf_rd` taken while `fifo_mode` is 1. It saturates at 0 and at DEPTH. A `buf_rd` with `fifo_mode` 0 leaves it unchanged. Bit 3 reads 1 exactly when the count is 0.
- R4: The selected channel count is loaded by `chsel_wr` from `chsel_val`. The completed-channel count resets on `seq_start` or `chsel_wr`. Bit 0 sets after the `seq_chan_done` that brings the completed count to the selected count. Completions taken while frozen or not running are ignored.
- R5: A `buf_rd` with `fifo_mode` 1 clears bit 0.
- R6: A `chsel_wr` clears bit 0.
- R7: A bus write to STAT_ADDR with data bit 0 set clears bit 0. A write with bit 0 clear, or to another address, leaves bit 0 unchanged.
- R8: While `mod_en` is 0, the block clears bit 0, the unread count, the running state and the frozen state.
- R9: A completion in the same cycle as a FIFO read, a channel-select write or a disable leaves bit 0 clear. A completion in the same cycle as a bus clear of bit 0 leaves bit 0 set.
- R10: Bit 2 reads 1 from the cycle after `seq_start` until the cycle after the final channel completion of a one-shot group.
- R11: While `cont_mode` is 1, bit 2 reads 1 and the final completion restarts the channel count without ending the run.
- R12: `seq_freeze` while running sets bit 1, and `seq_resume` clears it. Bit 2 stays 1 while bit 1 is 1.
- R13: `bus_rdata` equals `status` while `bus_rd` is 1 and `bus_addr` equals STAT_ADDR, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en | input | 1 | Module enable; low clears the group state |
| seq_start | input | 1 | Group conversion start strobe |
| seq_chan_done | input | 1 | One channel of the group finished |
| seq_freeze | input | 1 | Group frozen for another group |
| seq_resume | input | 1 | Frozen group resumes |
| cont_mode | input | 1 | Group set to continuous conversion |
| chsel_wr | input | 1 | Channel-select register write strobe |
| chsel_val | input | SEL_W | Number of channels selected by that write |
| buf_wr | input | 1 | Result written to the buffer |
| buf_rd | input | 1 | Result read from the buffer |
| fifo_mode | input | 1 | Buffer read in FIFO mode |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| status | output | 32 | Current status word |
| unread_cnt | output | CNT_W | Unread results in the buffer |

## Verification
The end flag has a set path and several clear paths, and the case to settle is a set and a clear landing in the same cycle. The bench drives the final `seq_chan_done` of a group in the same cycle as a bus clear of bit 0, and expects the flag to stay set. It then drives the final completion in the same cycle as a `chsel_wr`, and expects the flag to end up clear. A freeze arriving while a completion is pending is also checked: that completion must be ignored.

// File: rtl/grp_stat_pkg.sv
package grp_stat_pkg;
   localparam int STAT_W    = 32;
   localparam int BIT_END   = 0;
   localparam int BIT_STOP  = 1;
   localparam int BIT_BUSY  = 2;
   localparam int BIT_EMPTY = 3;
   localparam int USED_BITS = 4;

   function automatic logic [STAT_W-1:0] pack_status(
      input logic empty, input logic busy, input logic stop, input logic done_f);
      logic [STAT_W-1:0] w;
      w = '0;
      w[BIT_EMPTY] = empty;
      w[BIT_BUSY]  = busy;
      w[BIT_STOP]  = stop;
      w[BIT_END]   = done_f;
      return w;
   endfunction
endpackage

// File: rtl/gst_fill_counter.sv
module gst_fill_counter #(
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             empty
);
   localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH);

   logic [CNT_W-1:0] cnt_q;
   logic             do_inc, do_dec;

   assign do_inc = inc && (cnt_q != MAX_CNT);
   assign do_dec = dec && (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (do_inc && !do_dec) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (do_dec && !do_inc) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt   = cnt_q;
   assign empty = (cnt_q == '0);
endmodule

// File: rtl/gst_run_ctrl.sv
module gst_run_ctrl #(
   parameter int SEL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             start,
   input  logic             chan_done,
   input  logic             freeze,
   input  logic             resume,
   input  logic             cont,
   input  logic             chsel_wr,
   input  logic [SEL_W-1:0] chsel_val,
   output logic             running,
   output logic             frozen,
   output logic             complete
);
   logic [SEL_W-1:0] sel_q;
   logic [SEL_W-1:0] done_q;
   logic             run_q, frz_q;
   logic             take;

   assign take     = en && run_q && !frz_q && chan_done;
   assign complete = take && (SEL_W'(done_q + 1'b1) == sel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (chsel_wr) begin
         sel_q <= chsel_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= '0;
      end else if (!en || start || chsel_wr) begin
         done_q <= '0;
      end else if (take) begin
         done_q <= complete ? '0 : done_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (!en) begin
         run_q <= 1'b0;
      end else if (start) begin
         run_q <= 1'b1;
      end else if (complete && !cont) begin
         run_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frz_q <= 1'b0;
      end else if (!en) begin
         frz_q <= 1'b0;
      end else if (freeze && run_q) begin
         frz_q <= 1'b1;
      end else if (resume) begin
         frz_q <= 1'b0;
      end
   end

   assign running = run_q;
   assign frozen  = frz_q;
endmodule

// File: rtl/gst_end_flag.sv
module gst_end_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic hw_clr,
   input  logic sw_clr,
   output logic flag
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (hw_clr) begin
         flag_q <= 1'b0;
      end else if (set) begin
         flag_q <= 1'b1;
      end else if (sw_clr) begin
         flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;
endmodule

// File: rtl/grp_stat_tracker.sv
module grp_stat_tracker #(
   parameter int              NCH       = 16,
   parameter int              DEPTH     = 16,
   parameter int              AW        = 4,
   parameter logic [AW-1:0]   STAT_ADDR = '0,
   parameter int              SEL_W     = $clog2(NCH + 1),
   parameter int              CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           mod_en,
   input  logic                           seq_start,
   input  logic                           seq_chan_done,
   input  logic                           seq_freeze,
   input  logic                           seq_resume,
   input  logic                           cont_mode,
   input  logic                           chsel_wr,
   input  logic [SEL_W-1:0]               chsel_val,
   input  logic                           buf_wr,
   input  logic                           buf_rd,
   input  logic                           fifo_mode,
   input  logic                           bus_rd,
   input  logic                           bus_wr,
   input  logic [AW-1:0]                  bus_addr,
   input  logic [grp_stat_pkg::STAT_W-1:0] bus_wdata,
   output logic [grp_stat_pkg::STAT_W-1:0] bus_rdata,
   output logic [grp_stat_pkg::STAT_W-1:0] status,
   output logic [CNT_W-1:0]               unread_cnt
);
   import grp_stat_pkg::*;

   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end
   if (SEL_W < $clog2(NCH + 1)) begin : g_bad_selw
      $error("SEL_W too narrow for NCH");
   end
   if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cntw
      $error("CNT_W too narrow for DEPTH");
   end

   logic addr_hit, fifo_read, sw_clr, hw_clr;
   logic running, frozen, complete, end_f, empty;

   assign addr_hit  = (bus_addr == STAT_ADDR);
   assign fifo_read = buf_rd && fifo_mode;
   assign sw_clr    = bus_wr && addr_hit && bus_wdata[BIT_END];
   assign hw_clr    = fifo_read || chsel_wr || !mod_en;

   gst_fill_counter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fill (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!mod_en),
      .inc   (buf_wr),
      .dec   (fifo_read),
      .cnt   (unread_cnt),
      .empty (empty)
   );

   gst_run_ctrl #(.SEL_W(SEL_W)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (mod_en),
      .start     (seq_start),
      .chan_done (seq_chan_done),
      .freeze    (seq_freeze),
      .resume    (seq_resume),
      .cont      (cont_mode),
      .chsel_wr  (chsel_wr),
      .chsel_val (chsel_val),
      .running   (running),
      .frozen    (frozen),
      .complete  (complete)
   );

   gst_end_flag u_end (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (complete),
      .hw_clr (hw_clr),
      .sw_clr (sw_clr),
      .flag   (end_f)
   );

   assign status    = pack_status(empty, running || frozen || cont_mode, frozen, end_f);
   assign bus_rdata = (bus_rd && addr_hit) ? status : '0;
endmodule

// File: rtl/grp_stat_tracker_chk.sv
module grp_stat_tracker_chk #(
   parameter int            DEPTH     = 16,
   parameter int            AW        = 4,
   parameter logic [AW-1:0] STAT_ADDR = '0,
   parameter int            CNT_W     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mod_en,
   input logic              seq_chan_done,
   input logic              seq_freeze,
   input logic              seq_resume,
   input logic              chsel_wr,
   input logic              buf_rd,
   input logic              fifo_mode,
   input logic              bus_wr,
   input logic [AW-1:0]     bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       status,
   input logic [CNT_W-1:0]  unread_cnt
);
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      status[31:4] == '0); // R2
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      unread_cnt <= CNT_W'(DEPTH)); // R3
   AST_FIFO_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_rd && fifo_mode) |=> !status[0]); // R5
   AST_CHSEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      chsel_wr |=> !status[0]); // R6
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == STAT_ADDR && bus_wdata[0] && !seq_chan_done) |=> !status[0]); // R7
   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_en |=> (!status[0] && unread_cnt == '0 && !status[1])); // R8
   AST_STOP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      status[1] |-> status[2]); // R12
   AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_resume && !seq_freeze) |=> !status[1]); // R12
endmodule

bind grp_stat_tracker grp_stat_tracker_chk #(
   .DEPTH(DEPTH), .AW(AW), .STAT_ADDR(STAT_ADDR), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .seq_chan_done(seq_chan_done),
   .seq_freeze(seq_freeze), .seq_resume(seq_resume), .chsel_wr(chsel_wr),
   .buf_rd(buf_rd), .fifo_mode(fifo_mode), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .status(status), .unread_cnt(unread_cnt)
);

// File: tb/grp_stat_tracker_tb.sv
module grp_stat_tracker_tb;
   localparam int CLK_P = 10;
   localparam int NCH   = 16;
   localparam int DEPTH = 4;
   localparam int AW    = 4;
   localparam int SEL_W = $clog2(NCH + 1);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic clk = 0, rst_n = 0, mod_en = 1;
   logic seq_start = 0, seq_chan_done = 0, seq_freeze = 0, seq_resume = 0, cont_mode = 0;
   logic chsel_wr = 0;
   logic [SEL_W-1:0] chsel_val = '0;
   logic buf_wr = 0, buf_rd = 0, fifo_mode = 0, bus_rd = 0, bus_wr = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata, status;
   logic [CNT_W-1:0] unread_cnt;

   int checks = 0, errors = 0;
   bit done_flag = 0;
   logic [31:0] q_st[$];
   int          q_cnt[$];
   string       q_tag[$];

   always #(CLK_P/2) clk = ~clk;

   grp_stat_tracker #(.NCH(NCH), .DEPTH(DEPTH), .AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .seq_start(seq_start),
      .seq_chan_done(seq_chan_done), .seq_freeze(seq_freeze), .seq_resume(seq_resume),
      .cont_mode(cont_mode), .chsel_wr(chsel_wr), .chsel_val(chsel_val),
      .buf_wr(buf_wr), .buf_rd(buf_rd), .fifo_mode(fifo_mode), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .status(status), .unread_cnt(unread_cnt)
   );

   // monitor: pop expected item for the edge just taken
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_st.size() > 0) begin
            logic [31:0] es;
            int ec;
            string et;
            es = q_st.pop_front();
            ec = q_cnt.pop_front();
            et = q_tag.pop_front();
            checks++;
            if (status !== es || int'(unread_cnt) != ec) begin
               errors++;
               $display("FAIL %s: status=%h cnt=%0d expected status=%h cnt=%0d",
                        et, status, unread_cnt, es, ec);
            end
         end
      end
   end

   // driver: push expectation for the coming edge, then release strobes
   task automatic go(input string tag, input logic [3:0] f, input int cnt);
      q_st.push_back({28'h0, f});
      q_cnt.push_back(cnt);
      q_tag.push_back(tag);
      @(negedge clk);
      seq_start = 0; seq_chan_done = 0; seq_freeze = 0; seq_resume = 0;
      chsel_wr = 0; buf_wr = 0; buf_rd = 0; bus_wr = 0; bus_rd = 0;
      bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic chk_rd(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
      bus_rd = 1; bus_addr = a;
      #1;
      checks++;
      if (bus_rdata !== exp) begin
         errors++;
         $display("FAIL %s: rdata=%h expected %h", tag, bus_rdata, exp);
      end
      bus_rd = 0; bus_addr = '0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 20000);
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // {empty,busy,stop,end}
      go("R1 reset state", 4'b1000, 0);
      chk_rd("R13 read at status address", 4'd0, 32'h8);
      chk_rd("R13 read at other address", 4'd1, 32'h0);
      chsel_wr = 1; chsel_val = 2; go("R6 select two channels", 4'b1000, 0);
      seq_start = 1;     go("R10 busy after start", 4'b1100, 0);
      seq_chan_done = 1; go("R4 first channel", 4'b1100, 0);
      seq_chan_done = 1; go("R4 end on last channel", 4'b1001, 0);
      bus_wr = 1; bus_wdata = 32'h1; go("R7 write one clears end", 4'b1000, 0);
      seq_start = 1;     go("R10 restart", 4'b1100, 0);
      seq_chan_done = 1; go("R4 channel", 4'b1100, 0);
      seq_chan_done = 1; go("R4 end again", 4'b1001, 0);
      bus_wr = 1; bus_wdata = 32'hFFFF_FFF0; go("R7 R2 write zero bit0 no effect", 4'b1001, 0);
      bus_wr = 1; bus_addr = 4'd5; bus_wdata = 32'h1; go("R7 other address no effect", 4'b1001, 0);
      chsel_wr = 1; chsel_val = 2; go("R6 chsel clears end", 4'b1000, 0);
      buf_wr = 1; go("R3 write one", 4'b0000, 1);
      buf_wr = 1; go("R3 write two", 4'b0000, 2);
      seq_start = 1;     go("R10 start", 4'b0100, 2);
      seq_chan_done = 1; go("R4 channel", 4'b0100, 2);
      seq_chan_done = 1; go("R4 end", 4'b0001, 2);
      fifo_mode = 1;
      buf_rd = 1; go("R5 FIFO read clears end", 4'b0000, 1);
      buf_rd = 1; go("R3 empty after last read", 4'b1000, 0);
      buf_rd = 1; go("R3 saturate at zero", 4'b1000, 0);
      for (int i = 1; i <= DEPTH + 1; i++) begin
         buf_wr = 1; go("R3 fill and saturate", 4'b0000, (i > DEPTH) ? DEPTH : i);
      end
      fifo_mode = 0;
      buf_rd = 1; go("R3 non-FIFO read ignored", 4'b0000, DEPTH);
      fifo_mode = 1;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         buf_rd = 1; go("R3 drain", (i == 0) ? 4'b1000 : 4'b0000, i);
      end
      seq_start = 1;     go("R10 start", 4'b1100, 0);
      seq_freeze = 1;    go("R12 freeze sets stopped", 4'b1110, 0);
      seq_chan_done = 1; go("R4 completion while frozen ignored", 4'b1110, 0);
      seq_resume = 1;    go("R12 resume clears stopped", 4'b1100, 0);
      seq_chan_done = 1; go("R4 channel", 4'b1100, 0);
      seq_chan_done = 1; go("R12 end after resume", 4'b1001, 0);
      seq_start = 1;     go("R10 start keeps end", 4'b1101, 0);
      seq_chan_done = 1; go("R4 channel", 4'b1101, 0);
      seq_chan_done = 1; bus_wr = 1; bus_wdata = 32'h1;
      go("R9 completion beats write-one", 4'b1001, 0);
      bus_wr = 1; bus_wdata = 32'h1; go("R7 clear", 4'b1000, 0);
      seq_start = 1;     go("R10 start", 4'b1100, 0);
      seq_chan_done = 1; go("R4 channel", 4'b1100, 0);
      seq_chan_done = 1; chsel_wr = 1; chsel_val = 2;
      go("R9 chsel beats completion", 4'b1000, 0);
      cont_mode = 1;     go("R11 busy in continuous idle", 4'b1100, 0);
      seq_start = 1;     go("R11 start", 4'b1100, 0);
      seq_chan_done = 1; go("R11 channel", 4'b1100, 0);
      seq_chan_done = 1; go("R11 end keeps running", 4'b1101, 0);
      seq_chan_done = 1; go("R11 next pass", 4'b1101, 0);
      cont_mode = 0;     go("R11 still running after mode off", 4'b1101, 0);
      buf_wr = 1;        go("R3 write", 4'b0101, 1);
      mod_en = 0;        go("R8 disable clears", 4'b1000, 0);
      mod_en = 1;        go("R8 stays idle", 4'b1000, 0);
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule